// File: doc/BRIEF.md
# Aspect-Configurable Block RAM

A 16 Kbit synchronous on-chip memory that software-free configuration inputs shape into one of several depth-by-width geometries. The same bit storage can be seen as 16384 words of 1 bit, 8192 of 2, and so on up to 256 words of 64 bits. A word of width W at address a always occupies the linear storage bits a*W up to a*W+W-1, so data written in one shape can be read back in another.

The memory runs either with a single port or with two true ports that share one clock. In single-port mode, port A owns the low W bits of the 64-bit write and read buses. In dual-port mode, port A keeps the low W bits and port B takes the next W bits of both buses. A dual-port request for the 64-bit shape is not possible and falls back to single-port behaviour. Reads are registered and return the contents held before the writes of the same cycle. When both ports write the same bits in one cycle, port B's data is stored.

Top module: `aspect_bram`

## Requirements
- R1: While `rst` is high, and in the cycle after it was high, `rd_data` is all zero.
- R2: `cfg_shape` holds log2 of the word width (0 gives 1 bit, 6 gives 64 bits) and the depth is 16384 divided by the width. Only the low 14-log2(width) address bits are used, so addresses that differ only in the upper bits reach the same word.
- R3: The word of width W at address a is stored in linear bits a*W to a*W+W-1, so a value written in one shape is read back in another shape at the matching address.
- R4: In single-port mode (`cfg_dual` = 0), a write with `wen_a` stores `wr_data[W-1:0]` at `addr_a`. The word at `addr_a` appears on `rd_data[W-1:0]` after the next clock edge, with every higher bit zero. `addr_b` and `wen_b` have no effect.
- R5: In dual-port mode with a width of 32 or less, port B writes `wr_data[2W-1:W]` at `addr_b` when `wen_b` is high. Its word appears on `rd_data[2W-1:W]`, and bits 2W and above are zero.
- R6: With `cfg_dual` = 1 and the 64-bit shape, the memory behaves exactly as in single-port mode and `wen_b` is ignored.
- R7: A read in the same cycle as a write to the same word returns the contents before that write.
- R8: When both ports write the same word in the same cycle, port B's data is stored.
- R9: Two writes in one cycle to different words that share a 64-bit storage row both take effect.
- R10: `cfg_shape` value 7 behaves as value 6 (256x64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of the read registers |
| cfg_shape | input | 3 | log2 of the word width, held static |
| cfg_dual | input | 1 | 1 selects two independent ports |
| addr_a | input | 14 | Port A word address |
| addr_b | input | 14 | Port B word address |
| wr_data | input | 64 | Shared write bus; A uses the low lane, B the next lane |
| wen_a | input | 1 | Port A write enable |
| wen_b | input | 1 | Port B write enable, used in dual-port mode only |
| rd_data | output | 64 | Shared read bus split the same way; unused bits are zero |

## Verification
Two events can fall in the same cycle: a write on each port, and a read of a word that is being written. The bench provokes both with directed cases in which the two ports write the same word, or neighbouring words of one row, and with long random runs over a pool of 32 addresses. In those runs, reads, writes on both ports and colliding addresses coincide often. Each read is judged against a bench bit-array model. The model takes the expected read value before applying that cycle's writes, then applies port A's write before port B's.

// File: rtl/aspect_bram_pkg.sv
package aspect_bram_pkg;
  parameter int unsigned DEF_BUS_W  = 64;
  parameter int unsigned DEF_ADDR_W = 14;
  parameter int unsigned NPORTS     = 2;
  typedef enum int unsigned {PORT_A = 0, PORT_B = 1} port_id_e;
endpackage

// File: rtl/aspect_bram_addr_map.sv
module aspect_bram_addr_map #(
  parameter int unsigned BUS_W  = 64,
  parameter int unsigned ADDR_W = 14,
  localparam int unsigned LG_BUS = $clog2(BUS_W),
  localparam int unsigned SHP_W  = $clog2(LG_BUS + 1),
  localparam int unsigned ROW_W  = ADDR_W - LG_BUS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SHP_W-1:0]  shape,
  output logic [ROW_W-1:0]  row,
  output logic [LG_BUS-1:0] off,
  output logic [BUS_W-1:0]  wmask
);
  logic [ADDR_W-1:0] eff;
  logic [ADDR_W-1:0] lane;

  // keep only the address bits the selected depth uses
  assign eff   = addr & ~({ADDR_W{1'b1}} << (ADDR_W - 32'(shape)));
  // words per row = BUS_W / width; upper part picks the row
  assign row   = ROW_W'(eff >> (LG_BUS - 32'(shape)));
  assign lane  = eff & ~({ADDR_W{1'b1}} << (LG_BUS - 32'(shape)));
  assign off   = LG_BUS'(lane << shape);
  assign wmask = ~({BUS_W{1'b1}} << (1 << shape));
endmodule

// File: rtl/aspect_bram_lane_sel.sv
module aspect_bram_lane_sel #(
  parameter int unsigned BUS_W = 64,
  localparam int unsigned LG_BUS = $clog2(BUS_W),
  localparam int unsigned SHP_W  = $clog2(LG_BUS + 1)
) (
  input  logic [BUS_W-1:0]  row_q,
  input  logic [LG_BUS-1:0] off_q,
  input  logic [SHP_W-1:0]  shape_q,
  output logic [BUS_W-1:0]  word
);
  assign word = (row_q >> off_q) & ~({BUS_W{1'b1}} << (1 << shape_q));
endmodule

// File: rtl/aspect_bram_store.sv
module aspect_bram_store #(
  parameter int unsigned BUS_W = 64,
  parameter int unsigned ROW_W = 8,
  localparam int unsigned ROWS = 1 << ROW_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_a,
  input  logic [ROW_W-1:0] row_a,
  input  logic [BUS_W-1:0] bits_a,
  input  logic [BUS_W-1:0] mask_a,
  input  logic             we_b,
  input  logic [ROW_W-1:0] row_b,
  input  logic [BUS_W-1:0] bits_b,
  input  logic [BUS_W-1:0] mask_b,
  output logic [BUS_W-1:0] q_a,
  output logic [BUS_W-1:0] q_b
);
  logic [BUS_W-1:0] mem [ROWS];
  logic [BUS_W-1:0] nxt_a, base_b, nxt_b;

  // lane merge; port B builds on port A's result when both hit one row
  assign nxt_a  = (mem[row_a] & ~mask_a) | bits_a;
  assign base_b = (we_a && (row_a == row_b)) ? nxt_a : mem[row_b];
  assign nxt_b  = (base_b & ~mask_b) | bits_b;

  always_ff @(posedge clk) begin
    if (we_a) mem[row_a] <= nxt_a;
    if (we_b) mem[row_b] <= nxt_b;
  end

  // registered read of the old row contents
  always_ff @(posedge clk) begin
    if (rst) begin
      q_a <= '0;
      q_b <= '0;
    end else begin
      q_a <= mem[row_a];
      q_b <= mem[row_b];
    end
  end
endmodule

// File: rtl/aspect_bram.sv
module aspect_bram
  import aspect_bram_pkg::*;
#(
  parameter int unsigned BUS_W  = DEF_BUS_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  localparam int unsigned LG_BUS = $clog2(BUS_W),
  localparam int unsigned SHP_W  = $clog2(LG_BUS + 1),
  localparam int unsigned ROW_W  = ADDR_W - LG_BUS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SHP_W-1:0]  cfg_shape,
  input  logic              cfg_dual,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              wen_a,
  input  logic              wen_b,
  output logic [BUS_W-1:0]  rd_data
);
  localparam logic [SHP_W-1:0] SHP_MAX = SHP_W'(LG_BUS);

  logic [SHP_W-1:0]  shape;
  logic              dual_ok;
  logic [ADDR_W-1:0] p_addr [NPORTS];
  logic [BUS_W-1:0]  p_data [NPORTS];
  logic              p_we   [NPORTS];
  logic [ROW_W-1:0]  p_row  [NPORTS];
  logic [LG_BUS-1:0] p_off  [NPORTS];
  logic [BUS_W-1:0]  p_wm   [NPORTS];
  logic [BUS_W-1:0]  p_bits [NPORTS];
  logic [BUS_W-1:0]  p_mask [NPORTS];
  logic [BUS_W-1:0]  p_q    [NPORTS];
  logic [LG_BUS-1:0] off_q  [NPORTS];
  logic [BUS_W-1:0]  p_word [NPORTS];
  logic [SHP_W-1:0]  shape_q;
  logic              dual_q;

  // shape codes above the widest shape fold onto it
  assign shape   = (cfg_shape > SHP_MAX) ? SHP_MAX : cfg_shape;
  assign dual_ok = cfg_dual && (shape != SHP_MAX);

  assign p_addr[PORT_A] = addr_a;
  assign p_addr[PORT_B] = addr_b;
  assign p_data[PORT_A] = wr_data;
  assign p_data[PORT_B] = wr_data >> (1 << shape);
  assign p_we[PORT_A]   = wen_a;
  assign p_we[PORT_B]   = wen_b && dual_ok;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    aspect_bram_addr_map #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_map (
      .addr  (p_addr[g]),
      .shape (shape),
      .row   (p_row[g]),
      .off   (p_off[g]),
      .wmask (p_wm[g])
    );

    assign p_bits[g] = (p_data[g] & p_wm[g]) << p_off[g];
    assign p_mask[g] = p_wm[g] << p_off[g];

    always_ff @(posedge clk) begin
      if (rst) off_q[g] <= '0;
      else     off_q[g] <= p_off[g];
    end

    aspect_bram_lane_sel #(.BUS_W(BUS_W)) u_sel (
      .row_q   (p_q[g]),
      .off_q   (off_q[g]),
      .shape_q (shape_q),
      .word    (p_word[g])
    );
  end

  aspect_bram_store #(.BUS_W(BUS_W), .ROW_W(ROW_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we_a   (p_we[PORT_A]),
    .row_a  (p_row[PORT_A]),
    .bits_a (p_bits[PORT_A]),
    .mask_a (p_mask[PORT_A]),
    .we_b   (p_we[PORT_B]),
    .row_b  (p_row[PORT_B]),
    .bits_b (p_bits[PORT_B]),
    .mask_b (p_mask[PORT_B]),
    .q_a    (p_q[PORT_A]),
    .q_b    (p_q[PORT_B])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shape_q <= '0;
      dual_q  <= 1'b0;
    end else begin
      shape_q <= shape;
      dual_q  <= dual_ok;
    end
  end

  assign rd_data = p_word[PORT_A] |
                   (dual_q ? (p_word[PORT_B] << (1 << shape_q)) : '0);
endmodule

// File: rtl/aspect_bram_chk.sv
module aspect_bram_chk #(
  parameter int unsigned BUS_W  = 64,
  parameter int unsigned ADDR_W = 14,
  localparam int unsigned LG_BUS = $clog2(BUS_W),
  localparam int unsigned SHP_W  = $clog2(LG_BUS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [SHP_W-1:0]  cfg_shape,
  input logic              cfg_dual,
  input logic [ADDR_W-1:0] addr_a,
  input logic [ADDR_W-1:0] addr_b,
  input logic [BUS_W-1:0]  wr_data,
  input logic              wen_a,
  input logic              wen_b,
  input logic [BUS_W-1:0]  rd_data
);
  localparam logic [SHP_W-1:0] SHP_MAX = SHP_W'(LG_BUS);

  function automatic logic [BUS_W-1:0] lmask(input logic [SHP_W-1:0] s);
    return ~({BUS_W{1'b1}} << (1 << s));
  endfunction

  logic [SHP_W-1:0]  sh, sh_q, sh1;
  logic              dok, dok_q, dok1;
  logic [ADDR_W-1:0] am, adr1;
  logic              hit1, hit2;
  logic [BUS_W-1:0]  val1, val2;

  assign sh  = (cfg_shape > SHP_MAX) ? SHP_MAX : cfg_shape;
  assign dok = cfg_dual && (sh != SHP_MAX);
  assign am  = ~({ADDR_W{1'b1}} << (ADDR_W - 32'(sh)));

  always_ff @(posedge clk) begin
    sh_q  <= sh;
    dok_q <= dok;
    val1  <= (wr_data >> (1 << sh)) & lmask(sh);
    adr1  <= addr_a & am;
    sh1   <= sh;
    dok1  <= dok;
    val2  <= val1;
  end

  // collision write followed by an idle read of the same word
  always_ff @(posedge clk) begin
    if (rst) begin
      hit1 <= 1'b0;
      hit2 <= 1'b0;
    end else begin
      hit1 <= dok && wen_a && wen_b && ((addr_a & am) == (addr_b & am));
      hit2 <= hit1 && !wen_a && !wen_b && (sh == sh1) && (dok == dok1) &&
              ((addr_a & am) == adr1);
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (rd_data == '0)); // R1
  AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    !dok_q |-> ((rd_data & ~lmask(sh_q)) == '0)); // R4
  AST_DUAL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    dok_q |-> ((rd_data >> (2 << sh_q)) == '0)); // R5
  AST_COLLIDE_B_WINS: assert property (@(posedge clk) disable iff (rst)
    hit2 |-> ((rd_data & lmask(sh_q)) == val2)); // R8
endmodule

bind aspect_bram aspect_bram_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_shape (cfg_shape),
  .cfg_dual  (cfg_dual),
  .addr_a    (addr_a),
  .addr_b    (addr_b),
  .wr_data   (wr_data),
  .wen_a     (wen_a),
  .wen_b     (wen_b),
  .rd_data   (rd_data)
);

// File: tb/test_aspect_bram.sv
`timescale 1ns/1ps
module test_aspect_bram;
  localparam int NBITS = 16384;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  cfg_shape;
  logic        cfg_dual;
  logic [13:0] addr_a, addr_b;
  logic [63:0] wr_data;
  logic        wen_a, wen_b;
  logic [63:0] rd_data;

  always #4 clk = ~clk;

  aspect_bram i_aspect_bram (
    .clk(clk), .rst(rst), .cfg_shape(cfg_shape), .cfg_dual(cfg_dual),
    .addr_a(addr_a), .addr_b(addr_b), .wr_data(wr_data),
    .wen_a(wen_a), .wen_b(wen_b), .rd_data(rd_data)
  );

  logic [NBITS-1:0] model;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic int eff_k(input logic [2:0] s);
    return (s > 3'd6) ? 6 : int'(s);
  endfunction

  function automatic logic [63:0] peek(input int a, input int w);
    logic [63:0] v = '0;
    for (int i = 0; i < w; i++) v[i] = model[a*w + i];
    return v;
  endfunction

  task automatic poke(input int a, input int w, input logic [63:0] v);
    for (int i = 0; i < w; i++) model[a*w + i] = v[i];
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at a falling edge, judge the read at the next one
  task automatic op(input logic [2:0] s, input logic dl, input logic [13:0] aa,
                    input logic [13:0] ab, input logic wa, input logic wb,
                    input logic [63:0] d, input bit chk, input string tag);
    int k, w, ea, eb;
    bit dok;
    logic [63:0] m, exp;
    k   = eff_k(s);
    w   = 1 << k;
    dok = dl && (k < 6);
    ea  = int'(aa) & ((1 << (14 - k)) - 1);
    eb  = int'(ab) & ((1 << (14 - k)) - 1);
    m   = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    cfg_shape = s; cfg_dual = dl; addr_a = aa; addr_b = ab;
    wen_a = wa; wen_b = wb; wr_data = d;
    exp = peek(ea, w);
    if (dok) exp = exp | (peek(eb, w) << w);
    if (wa) poke(ea, w, d & m);
    if (wb && dok) poke(eb, w, (d >> w) & m);
    @(negedge clk);
    if (chk) check(tag, rd_data, exp);
  endtask

  function automatic logic [13:0] rnd_addr(input int k);
    int db, base;
    db   = 14 - k;
    base = ($urandom_range(0, 3) == 0) ? int'($urandom) : int'($urandom_range(0, 31));
    base = base & ((1 << db) - 1);
    return 14'(base | (int'($urandom) << db));
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'd5179));
    model = '0;
    rst = 1'b1; cfg_shape = 3'd6; cfg_dual = 1'b0;
    addr_a = '0; addr_b = '0; wr_data = '0; wen_a = 1'b0; wen_b = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", rd_data, 64'd0);
    rst = 1'b0;

    // fill every row through the 64-bit shape
    for (int r = 0; r < 256; r++) op(3'd6, 1'b0, 14'(r), 14'd0, 1'b1, 1'b0, rnd64(), 1'b0, "init");
    for (int r = 0; r < 256; r++) op(3'd6, 1'b0, 14'(r), 14'd0, 1'b0, 1'b0, 64'd0, 1'b1, "R4");

    // R2 aliasing: upper address bits ignored
    op(3'd4, 1'b0, 14'd3, 14'd0, 1'b1, 1'b0, 64'h0000_0000_0000_BEEF, 1'b0, "R2");
    op(3'd4, 1'b0, 14'h1003, 14'd0, 1'b0, 1'b0, 64'd0, 1'b1, "R2");
    check("R2", rd_data, 64'h0000_0000_0000_BEEF);

    // R3 linear bit mapping across shapes
    op(3'd3, 1'b0, 14'd2, 14'd0, 1'b1, 1'b0, 64'h0000_0000_0000_00A5, 1'b0, "R3");
    op(3'd0, 1'b0, 14'd16, 14'd0, 1'b0, 1'b0, 64'd0, 1'b1, "R3");
    op(3'd0, 1'b0, 14'd17, 14'd0, 1'b0, 1'b0, 64'd0, 1'b1, "R3");
    op(3'd6, 1'b0, 14'd0, 14'd0, 1'b0, 1'b0, 64'd0, 1'b1, "R3");
    check("R3", (rd_data >> 16) & 64'hFF, 64'hA5);

    // R7 read returns data from before the same-cycle write
    op(3'd2, 1'b0, 14'd7, 14'd0, 1'b1, 1'b0, 64'h3, 1'b0, "R7");
    op(3'd2, 1'b0, 14'd7, 14'd0, 1'b1, 1'b0, 64'hC, 1'b1, "R7");
    check("R7", rd_data, 64'h3);
    op(3'd2, 1'b0, 14'd7, 14'd0, 1'b0, 1'b0, 64'd0, 1'b1, "R7");
    check("R7", rd_data, 64'hC);

    // R8 both ports write one word: port B stays
    op(3'd3, 1'b1, 14'd5, 14'd5, 1'b1, 1'b1, 64'h0000_0000_0000_2211, 1'b0, "R8");
    op(3'd3, 1'b1, 14'd5, 14'd5, 1'b0, 1'b0, 64'd0, 1'b1, "R8");
    check("R8", rd_data, 64'h0000_0000_0000_2222);

    // R9 neighbouring words of one row written together
    op(3'd3, 1'b1, 14'd8, 14'd9, 1'b1, 1'b1, 64'h0000_0000_0000_6655, 1'b0, "R9");
    op(3'd3, 1'b1, 14'd8, 14'd9, 1'b0, 1'b0, 64'd0, 1'b1, "R9");
    check("R9", rd_data, 64'h0000_0000_0000_6655);

    // R10 code 7 acts as the 64-bit single-port shape; R6 wen_b ignored
    op(3'd7, 1'b1, 14'd4, 14'd9, 1'b1, 1'b1, 64'h0123_4567_89AB_CDEF, 1'b0, "R10");
    op(3'd7, 1'b1, 14'd9, 14'd4, 1'b0, 1'b0, 64'd0, 1'b1, "R6");
    op(3'd6, 1'b0, 14'd4, 14'd0, 1'b0, 1'b0, 64'd0, 1'b1, "R10");
    check("R10", rd_data, 64'h0123_4567_89AB_CDEF);

    // random traffic in every shape and mode
    for (int s = 0; s < 7; s++) begin
      for (int dl = 0; dl < 2; dl++) begin
        for (int n = 0; n < 300; n++) begin
          op(3'(s), 1'(dl), rnd_addr(s), rnd_addr(s), 1'($urandom), 1'($urandom),
             rnd64(), 1'b1, (dl == 0) ? "R4" : ((s == 6) ? "R6" : "R5"));
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run incomplete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule